// File: doc/BRIEF.md
# Palette RAM Write-Enable Controller

This block sits in the host register interface of a video processor and decides when an external 32-byte palette SRAM may be written. The host CPU reaches the block through a 3-bit register select, an active-low chip enable, a read/write line (1 = read, 0 = write) and an 8-bit data bus. The host loads an internal 14-bit video address through an address register and moves bytes through a separate data register. The block drives the SRAM's 5-bit address and its active-low write enable.

A write enable that checked only the register select latched at the start of an access would be exposed to a hazard. After a block of data-register writes, the latched select still points at the data register. When the host then begins a write to the address register, the write enable would pulse low before the new select is latched, and the address-register byte would land in palette memory, most often in the background entry. This block requires both the latched select and the live select to name the data register. Hosts that rewrite the whole palette in every vertical blanking interval therefore leave it intact.

The whole interface is sampled by a system clock that runs well faster than host accesses. The write-enable output itself is combinational, so it follows the host strobes without delay.

Top module: `pal_we_ctrl`

## Requirements
- R1: While rst_ni is low, pal_we_no is 1 and pal_addr_o is 0. Reset clears the video address and the address-load toggle, so the next select-6 write is taken as a high byte.
- R2: A write with select 6 (rw_i = 0) loads the video address in two steps. The first write holds data bits 5:0 as the high part and leaves the address unchanged. The second write sets the address to {held high part, data byte}. Data bits 7:6 of the high byte are ignored.
- R3: A read with select 2 (rw_i = 1) clears the address-load toggle, so the next select-6 write is again a high byte.
- R4: Each completed access with select 7, read or write, increments the video address by 1 and wraps from 0x3FFF to 0x0000. The increment takes effect on the clock edge after chip enable rises.
- R5: pal_addr_o always equals bits 4:0 of the video address and stays stable while pal_we_no is low.
- R6: pal_we_no is 0 only when all of these hold: the video address is in 0x3F00..0x3F1F, the select latched at the chip-enable fall is 7, the live select is 7, rw_i is 0, and ce_ni is 0. A write to select 7 outside that window gives no pulse.
- R7: A write to select 6 that follows data-register writes never pulses pal_we_no, including during the interval before the new select is latched.
- R8: Writing all 32 palette bytes from 0x3F00 and then reloading the address, repeated frame after frame, gives exactly one pulse per in-window byte and leaves every entry, including entry 0, holding the byte written to it.
- R9: The register select is latched on the clock after chip enable falls. The data byte used at the end of an access is the last value sampled while chip enable was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, faster than host accesses |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ce_ni | input | 1 | Host chip enable, active low |
| rw_i | input | 1 | Host direction: 1 = read, 0 = write |
| reg_sel_i | input | 3 | Host register select (2 status, 6 address, 7 data) |
| data_i | input | 8 | Host data bus |
| pal_addr_o | output | 5 | Palette SRAM address |
| pal_we_no | output | 1 | Palette SRAM write enable, active low |

## Verification
On every cycle, the assertions check four things: a write pulse never coincides with a host read or an idle chip enable; a select-6 access never pulls the enable low; the SRAM address holds still across a pulse; the latched select and captured data match the host bus. Each data access must advance the address by one, and a status read must clear the toggle. Only the bench's scenarios show that palette contents come out right: repeated full-frame rewrites, blocks straddling both window edges, address wrap, and a reset or status read in the middle of an address load. The bench checks these against its own SRAM model, fed by the design's pins.

// File: rtl/pal_we_pkg.sv
package pal_we_pkg;
  localparam int unsigned VA_W_DEF   = 14;
  localparam int unsigned DW_DEF     = 8;
  localparam int unsigned SEL_W_DEF  = 3;
  localparam int unsigned PAL_AW_DEF = 5;
  localparam int unsigned PAL_BASE_DEF = 32'h3F00;

  localparam int unsigned SEL_STATUS_CODE = 2;
  localparam int unsigned SEL_ADDR_CODE   = 6;
  localparam int unsigned SEL_DATA_CODE   = 7;
endpackage

// File: rtl/pal_bus_capture.sv
module pal_bus_capture #(
  parameter int unsigned SEL_W = 3,
  parameter int unsigned DW    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ce_ni,
  input  logic             rw_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [DW-1:0]    data_i,
  output logic [SEL_W-1:0] sel_lat_o,
  output logic             rd_lat_o,
  output logic [DW-1:0]    data_o,
  output logic             evt_o
);
  logic             ce_q;
  logic             fall;
  logic [SEL_W-1:0] sel_q;
  logic             rd_q;
  logic [DW-1:0]    data_q;

  assign fall = ce_q & ~ce_ni;
  assign evt_o = ~ce_q & ce_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_q   <= 1'b1;
      sel_q  <= '0;
      rd_q   <= 1'b1;
      data_q <= '0;
    end else begin
      ce_q <= ce_ni;
      if (fall) begin
        sel_q <= sel_i;
        rd_q  <= rw_i;
      end
      // keep the last byte seen while the access is open
      if (!ce_ni) data_q <= data_i;
    end
  end

  assign sel_lat_o = sel_q;
  assign rd_lat_o  = rd_q;
  assign data_o    = data_q;

  AST_SEL_LATCH_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall |=> sel_lat_o == $past(sel_i)); // R9
  AST_DATA_AT_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |-> data_o == $past(data_i)); // R9
endmodule

// File: rtl/pal_vaddr_reg.sv
module pal_vaddr_reg
  import pal_we_pkg::*;
#(
  parameter int unsigned VA_W  = 14,
  parameter int unsigned DW    = 8,
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             rd_i,
  input  logic [DW-1:0]    data_i,
  output logic [VA_W-1:0]  vaddr_o
);
  localparam int unsigned HI_W = VA_W - DW;
  localparam logic [SEL_W-1:0] SEL_S = SEL_W'(SEL_STATUS_CODE);
  localparam logic [SEL_W-1:0] SEL_A = SEL_W'(SEL_ADDR_CODE);
  localparam logic [SEL_W-1:0] SEL_D = SEL_W'(SEL_DATA_CODE);

  logic [VA_W-1:0] vaddr_q;
  logic [HI_W-1:0] hi_q;
  logic            tog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vaddr_q <= '0;
      hi_q    <= '0;
      tog_q   <= 1'b0;
    end else if (evt_i) begin
      if (sel_i == SEL_D) begin
        vaddr_q <= vaddr_q + 1'b1;
      end else if (sel_i == SEL_A && !rd_i) begin
        if (!tog_q) begin
          hi_q  <= data_i[HI_W-1:0];
          tog_q <= 1'b1;
        end else begin
          vaddr_q <= {hi_q, data_i};
          tog_q   <= 1'b0;
        end
      end else if (sel_i == SEL_S && rd_i) begin
        tog_q <= 1'b0;
      end
    end
  end

  assign vaddr_o = vaddr_q;

  AST_DATA_INCR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && sel_i == SEL_D) |=> vaddr_o == VA_W'($past(vaddr_o) + 1'b1)); // R4
  AST_STATUS_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && sel_i == SEL_S && rd_i) |=> !tog_q); // R3
  AST_HI_HOLDS_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && sel_i == SEL_A && !rd_i && !tog_q) |=> $stable(vaddr_o)); // R2
endmodule

// File: rtl/pal_we_gate.sv
module pal_we_gate
  import pal_we_pkg::*;
#(
  parameter int unsigned VA_W   = 14,
  parameter int unsigned SEL_W  = 3,
  parameter int unsigned PAL_AW = 5,
  parameter logic [VA_W-1:0] PAL_BASE = 14'h3F00
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [VA_W-1:0]   vaddr_i,
  input  logic [SEL_W-1:0]  sel_lat_i,
  input  logic [SEL_W-1:0]  sel_live_i,
  input  logic              rw_i,
  input  logic              ce_ni,
  output logic [PAL_AW-1:0] addr_o,
  output logic              we_no_o
);
  localparam logic [SEL_W-1:0] SEL_D = SEL_W'(SEL_DATA_CODE);

  logic in_win;
  logic sel_ok;

  assign in_win = vaddr_i[VA_W-1:PAL_AW] == PAL_BASE[VA_W-1:PAL_AW];
  // both the latched and the live select must name the data register
  assign sel_ok = (sel_lat_i == SEL_D) && (sel_live_i == SEL_D);
  assign we_no_o = !(rst_ni && in_win && sel_ok) || rw_i || ce_ni;
  assign addr_o  = vaddr_i[PAL_AW-1:0];

  AST_ADDR_STABLE_IN_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_no_o && $past(!we_no_o)) |-> $stable(addr_o)); // R5
endmodule

// File: rtl/pal_we_ctrl.sv
module pal_we_ctrl
  import pal_we_pkg::*;
#(
  parameter int unsigned VA_W   = VA_W_DEF,
  parameter int unsigned DW     = DW_DEF,
  parameter int unsigned SEL_W  = SEL_W_DEF,
  parameter int unsigned PAL_AW = PAL_AW_DEF,
  parameter logic [VA_W-1:0] PAL_BASE = VA_W'(PAL_BASE_DEF)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              rw_i,
  input  logic [SEL_W-1:0]  reg_sel_i,
  input  logic [DW-1:0]     data_i,
  output logic [PAL_AW-1:0] pal_addr_o,
  output logic              pal_we_no
);
  localparam logic [SEL_W-1:0] SEL_A = SEL_W'(SEL_ADDR_CODE);

  logic [SEL_W-1:0] sel_lat;
  logic             rd_lat;
  logic [DW-1:0]    cap_data;
  logic             evt;
  logic [VA_W-1:0]  vaddr;

  pal_bus_capture #(.SEL_W(SEL_W), .DW(DW)) u_cap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ce_ni     (ce_ni),
    .rw_i      (rw_i),
    .sel_i     (reg_sel_i),
    .data_i    (data_i),
    .sel_lat_o (sel_lat),
    .rd_lat_o  (rd_lat),
    .data_o    (cap_data),
    .evt_o     (evt)
  );

  pal_vaddr_reg #(.VA_W(VA_W), .DW(DW), .SEL_W(SEL_W)) u_vaddr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (evt),
    .sel_i   (sel_lat),
    .rd_i    (rd_lat),
    .data_i  (cap_data),
    .vaddr_o (vaddr)
  );

  pal_we_gate #(.VA_W(VA_W), .SEL_W(SEL_W), .PAL_AW(PAL_AW), .PAL_BASE(PAL_BASE)) u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .vaddr_i    (vaddr),
    .sel_lat_i  (sel_lat),
    .sel_live_i (reg_sel_i),
    .rw_i       (rw_i),
    .ce_ni      (ce_ni),
    .addr_o     (pal_addr_o),
    .we_no_o    (pal_we_no)
  );

  AST_WE_ONLY_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pal_we_no |-> (!rw_i && !ce_ni)); // R6
  AST_NO_ADDR_REG_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && reg_sel_i == SEL_A) |-> pal_we_no); // R7
  always_comb begin
    if (!rst_ni) AST_RESET_WE_HIGH: assert (pal_we_no); // R1
  end
endmodule

// File: tb/pal_we_ctrl_tb.sv
module pal_we_ctrl_tb;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce_n = 1'b1;
  logic       rw = 1'b1;
  logic [2:0] sel = 3'd0;
  logic [7:0] bus_d = 8'h00;
  logic [4:0] pal_addr_o;
  logic       pal_we_no;

  int total = 0;
  int bad = 0;
  int pulses = 0;
  bit done = 0;

  logic [7:0]  sram [32];
  logic [7:0]  exp_mem [32];
  logic [13:0] va = '0;
  logic [5:0]  hi = '0;
  bit          tog = 0;

  always #(CLK_P/2) clk = ~clk;

  pal_we_ctrl u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .ce_ni      (ce_n),
    .rw_i       (rw),
    .reg_sel_i  (sel),
    .data_i     (bus_d),
    .pal_addr_o (pal_addr_o),
    .pal_we_no  (pal_we_no)
  );

  // SRAM model: latches the bus byte when the write enable returns high
  always @(posedge pal_we_no) if (rst_n) sram[pal_addr_o] = bus_d;
  always @(negedge pal_we_no) if (rst_n) pulses++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic bit in_win(input logic [13:0] v);
    return (v >> 5) == (14'h3F00 >> 5);
  endfunction

  // one host access; the byte on the bus changes mid-access (R9)
  task automatic acc(input logic [2:0] s, input logic rd, input logic [7:0] d);
    int  p0;
    bit  exp_w;
    p0 = pulses;
    exp_w = (s == 3'd7) && !rd && in_win(va);
    @(negedge clk);
    sel = s; rw = rd; bus_d = ~d; ce_n = 1'b0;
    #1;
    if (s != 3'd7) chk(pal_we_no === 1'b1, "R7 early we", pal_we_no, 1);
    @(negedge clk);
    bus_d = d;
    if (exp_w) begin
      chk(pal_we_no === 1'b0, "R6 we low", pal_we_no, 0);
      chk(pal_addr_o == va[4:0], "R5 addr in pulse", pal_addr_o, va[4:0]);
    end else begin
      chk(pal_we_no === 1'b1, "R6 we high", pal_we_no, 1);
    end
    @(negedge clk);
    ce_n = 1'b1;
    @(negedge clk);
    chk(pulses - p0 == int'(exp_w), "R8 pulse count", pulses - p0, int'(exp_w));
    if (s == 3'd7) begin
      if (exp_w) exp_mem[va[4:0]] = d;
      va = va + 14'd1;
    end else if (s == 3'd6 && !rd) begin
      if (!tog) hi = d[5:0];
      else va = {hi, d};
      tog = !tog;
    end else if (s == 3'd2 && rd) begin
      tog = 0;
    end
    chk(pal_addr_o == va[4:0], "R4 R2 addr after", pal_addr_o, va[4:0]);
  endtask

  task automatic set_addr(input logic [15:0] a);
    acc(3'd6, 1'b0, a[15:8]);
    acc(3'd6, 1'b0, a[7:0]);
  endtask

  task automatic cmp_mem(input string req);
    for (int i = 0; i < 32; i++)
      chk(sram[i] == exp_mem[i], req, sram[i], exp_mem[i]);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) begin
      sram[i] = 8'h00;
      exp_mem[i] = 8'h00;
    end
    repeat (3) @(negedge clk);
    chk(pal_we_no === 1'b1, "R1 we in reset", pal_we_no, 1);
    chk(pal_addr_o == 5'd0, "R1 addr in reset", pal_addr_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8: full palette rewrite per frame, then an address reload (R7)
    for (int f = 0; f < 6; f++) begin
      set_addr(16'h3F00);
      for (int i = 0; i < 32; i++) acc(3'd7, 1'b0, 8'((f * 37 + i * 11) ^ 8'h5A));
      set_addr(16'h2000);
      acc(3'd7, 1'b0, 8'h10);
      chk(sram[0] == exp_mem[0], "R8 background entry", sram[0], exp_mem[0]);
      cmp_mem("R8 frame contents");
    end

    // R6: blocks straddling both window edges
    set_addr(16'h3EF0);
    for (int i = 0; i < 32; i++) acc(3'd7, 1'b0, 8'(i + 8'h80));
    set_addr(16'h3F10);
    for (int i = 0; i < 32; i++) acc(3'd7, 1'b0, 8'(i + 8'hC0));
    cmp_mem("R6 window edges");

    // R4: wrap at 14 bits
    set_addr(16'h3FFF);
    acc(3'd7, 1'b0, 8'hEE);
    chk(va == 14'd0, "R4 model wrap", va, 0);
    acc(3'd7, 1'b1, 8'h00);

    // R2: high-byte bits 7:6 ignored
    set_addr(16'hFF05);
    acc(3'd7, 1'b0, 8'h33);
    cmp_mem("R2 high bits ignored");

    // R4: data read advances the address
    set_addr(16'h3F08);
    acc(3'd7, 1'b1, 8'h00);
    acc(3'd7, 1'b0, 8'h44);
    cmp_mem("R4 read increments");

    // R3: status read clears the toggle
    acc(3'd6, 1'b0, 8'h12);
    acc(3'd2, 1'b1, 8'h00);
    set_addr(16'h3F0C);
    acc(3'd7, 1'b0, 8'h55);
    cmp_mem("R3 toggle cleared");

    // R1: reset mid-load clears toggle and address
    set_addr(16'h3F1A);
    acc(3'd6, 1'b0, 8'h3F);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(pal_addr_o == 5'd0, "R1 addr after reset", pal_addr_o, 0);
    chk(pal_we_no === 1'b1, "R1 we after reset", pal_we_no, 1);
    rst_n = 1'b1;
    va = '0;
    tog = 0;
    set_addr(16'h3F03);
    acc(3'd7, 1'b0, 8'h66);
    cmp_mem("R1 toggle after reset");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule